// File: doc/BRIEF.md
# Coalesced Translation Response Distributor

This block sits after a translation unit that serves merged address-translation requests. Several requests that fall in one virtual page are collected into a group. Only the group's leading request is translated. When that translation comes back, this block finds the group in its outstanding table by virtual page. It then answers every member of the group, one member per clock, each on the requester port the member came in on. The leader gets the returned physical address unchanged. Every later member gets a physical address built from the returned physical page and the member's own offset inside that page. The page size is taken from the returned translation, so pages larger than the base page work. The uncacheable flag and the hit level of the returned translation are copied onto every member's response. For members that are not prefetches, the per-level request depth is decremented on the way out.

The outstanding table is filled through an install port. An install to an empty slot opens a group keyed by the virtual page. An install to an occupied slot appends a member. The slot that is being answered is locked against installs. Its entry is released on the clock edge that completes the last response, so a new group can use the slot from the next cycle. A returned translation whose page matches no open group raises a one-cycle error flag and produces no responses.

Top module: `xlate_fan_dist`

## Requirements
- R1: A returned translation accepted at clock edge k gives its first response in the cycle after k. That response is the leader (member 0): `rspLead`=1 and `rspPaddr` equals the returned `xlPaddr` exactly.
- R2: For member i>0, with page mask M = 2^`xlShift` − 1 taken from the returned translation, `rspPaddr` = (`xlPaddr` AND NOT M) OR (member virtual address AND M), and `rspLead`=0.
- R3: Every response of a group, leader included, carries the returned `xlUncache` on `rspUncache` and the returned `xlHitLevel` on `rspHitLevel`.
- R4: Members are answered in the order they were installed. Bit p of `rspValid` is the only bit raised for a member installed with port number p.
- R5: At most one bit of `rspValid` is high in any cycle, and at most one member completes per cycle (a member completes when `rspValid` and `rspReady` are high on the same bit).
- R6: While the raised `rspValid` bit has `rspReady` low, the same bit and the same response fields are held in the next cycle.
- R7: `rspDepth` is the installed depth minus one for a non-prefetch member, held at 0 when the installed depth is 0. For a prefetch member it is the installed depth unchanged.
- R8: `xlReady` is low from the acceptance edge until the edge that completes the last member. The group's table entry is released on that same edge. From the next cycle, `xlReady` is high and `rspValid` is all zero, and a translation for the same page is a miss.
- R9: A translation accepted for a page with no open group sets `errMiss` high for exactly the one cycle after acceptance, raises no `rspValid` bit, and leaves `xlReady` high.
- R10: An install to an empty slot opens a group with page key `insVaddr`[ADDR_W-1:BASE_SHIFT] and one member. An install to an open slot appends a member. Installs past MEMBERS members are dropped.
- R11: An install that targets the slot currently being answered is dropped. Installs to other slots during answering are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Install one member into the table |
| insSlot | input | SLOT_W | Table slot for the install |
| insVaddr | input | ADDR_W | Member virtual address |
| insPort | input | PORT_W | Requester port of the member |
| insPrefetch | input | 1 | Member is a prefetch |
| insDepth | input | DEPTH_W | Member per-level request depth |
| xlValid | input | 1 | Returned translation present |
| xlReady | output | 1 | Block can accept a returned translation |
| xlPage | input | ADDR_W-BASE_SHIFT | Virtual page of the leading request |
| xlPaddr | input | ADDR_W | Translated physical address of the leader |
| xlShift | input | SHIFT_W | log2 of the translated page size |
| xlUncache | input | 1 | Translated page is uncacheable |
| xlHitLevel | input | HIT_W | Level at which the translation hit |
| rspValid | output | PORTS | One-hot response valid, one bit per requester port |
| rspReady | input | PORTS | Per-port ready |
| rspPaddr | output | ADDR_W | Physical address of the member being answered |
| rspUncache | output | 1 | Uncacheable flag for the member |
| rspHitLevel | output | HIT_W | Hit level for the member |
| rspDepth | output | DEPTH_W | Request depth after the decrement |
| rspLead | output | 1 | Response is for the group leader |
| errMiss | output | 1 | Returned translation matched no open group |

## Verification
A wrong member index or count shows up at the ports within the group's own burst. The bench sees a response on the wrong port bit, a response that never comes, or an extra response where `xlReady` should already be high one cycle after the last handshake. A wrong page mask or a stale captured translation corrupts `rspPaddr` on the first non-leader member, which is the second response cycle. A late or missing release of the table entry is visible on the next translation for the same page: it must report `errMiss` in the cycle after acceptance. Ready patterns that stall each member for one or two cycles show whether a stalled response holds steady or moves on too early.

// File: rtl/xlate_fan_pkg.sv
package xlate_fan_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } fan_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the returned translation
    logic lead;     // member being presented is the leader
  } fan_strobe_t;

endpackage

// File: rtl/xlate_fan_table.sv
module xlate_fan_table #(
  parameter int ADDR_W     = 16,
  parameter int BASE_SHIFT = 4,
  parameter int GROUPS     = 4,
  parameter int MEMBERS    = 4,
  parameter int PORTS      = 4,
  parameter int DEPTH_W    = 3,
  localparam int SLOT_W    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int IDX_W     = (MEMBERS > 1) ? $clog2(MEMBERS) : 1,
  localparam int CNT_W     = $clog2(MEMBERS + 1),
  localparam int PORT_W    = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int PAGE_W    = ADDR_W - BASE_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               insValid,
  input  logic [SLOT_W-1:0]  insSlot,
  input  logic [ADDR_W-1:0]  insVaddr,
  input  logic [PORT_W-1:0]  insPort,
  input  logic               insPrefetch,
  input  logic [DEPTH_W-1:0] insDepth,
  input  logic               lockValid,
  input  logic [SLOT_W-1:0]  lockSlot,
  input  logic               freeEn,
  input  logic [PAGE_W-1:0]  lookPage,
  output logic               lookHit,
  output logic [SLOT_W-1:0]  lookSlot,
  output logic [CNT_W-1:0]   lookCount,
  input  logic [SLOT_W-1:0]  rdSlot,
  input  logic [CNT_W-1:0]   rdIdx,
  output logic [ADDR_W-1:0]  rdVaddr,
  output logic [PORT_W-1:0]  rdPort,
  output logic               rdPrefetch,
  output logic [DEPTH_W-1:0] rdDepth
);

  logic [GROUPS-1:0]  entValid;
  logic [PAGE_W-1:0]  entPage  [GROUPS];
  logic [CNT_W-1:0]   entCount [GROUPS];
  logic [ADDR_W-1:0]  memVaddr [GROUPS][MEMBERS];
  logic [PORT_W-1:0]  memPort  [GROUPS][MEMBERS];
  logic               memPf    [GROUPS][MEMBERS];
  logic [DEPTH_W-1:0] memDepth [GROUPS][MEMBERS];

  logic insLocked;
  assign insLocked = lockValid && (insSlot == lockSlot);

  // per-slot control state
  for (genvar g = 0; g < GROUPS; g++) begin : gSlot
    logic insHere;
    assign insHere = insValid && !insLocked && (insSlot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[g] <= 1'b0;
        entCount[g] <= '0;
        entPage[g]  <= '0;
      end else if (freeEn && lockSlot == SLOT_W'(g)) begin
        entValid[g] <= 1'b0;
        entCount[g] <= '0;
      end else if (insHere) begin
        if (!entValid[g]) begin
          entValid[g] <= 1'b1;
          entPage[g]  <= insVaddr[ADDR_W-1:BASE_SHIFT];
          entCount[g] <= CNT_W'(1);
        end else if (entCount[g] < CNT_W'(MEMBERS)) begin
          entCount[g] <= entCount[g] + CNT_W'(1);
        end
      end
    end

    // member storage, no reset needed
    for (genvar m = 0; m < MEMBERS; m++) begin : gMem
      logic wrHere;
      assign wrHere = insHere &&
                      ((!entValid[g] && m == 0) ||
                       (entValid[g] && entCount[g] == CNT_W'(m)));
      always_ff @(posedge clk) begin
        if (wrHere) begin
          memVaddr[g][m] <= insVaddr;
          memPort[g][m]  <= insPort;
          memPf[g][m]    <= insPrefetch;
          memDepth[g][m] <= insDepth;
        end
      end
    end
  end

  // page lookup, lowest matching slot wins
  always_comb begin
    lookHit   = 1'b0;
    lookSlot  = '0;
    lookCount = '0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (entValid[g] && entPage[g] == lookPage) begin
        lookHit   = 1'b1;
        lookSlot  = SLOT_W'(g);
        lookCount = entCount[g];
      end
    end
  end

  // member read port
  logic [IDX_W-1:0] rdIdxT;
  assign rdIdxT     = rdIdx[IDX_W-1:0];
  assign rdVaddr    = memVaddr[rdSlot][rdIdxT];
  assign rdPort     = memPort[rdSlot][rdIdxT];
  assign rdPrefetch = memPf[rdSlot][rdIdxT];
  assign rdDepth    = memDepth[rdSlot][rdIdxT];

endmodule

// File: rtl/xlate_fan_ctrl.sv
module xlate_fan_ctrl
  import xlate_fan_pkg::*;
#(
  parameter int GROUPS  = 4,
  parameter int MEMBERS = 4,
  parameter int PORTS   = 4,
  localparam int SLOT_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int CNT_W  = $clog2(MEMBERS + 1),
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xlValid,
  output logic              xlReady,
  input  logic              lookHit,
  input  logic [SLOT_W-1:0] lookSlot,
  input  logic [CNT_W-1:0]  lookCount,
  input  logic [PORT_W-1:0] rdPort,
  input  logic [PORTS-1:0]  rspReady,
  output logic [PORTS-1:0]  rspValid,
  output logic [SLOT_W-1:0] curSlot,
  output logic [CNT_W-1:0]  curIdx,
  output logic              lockValid,
  output logic              freeEn,
  output logic              errMiss,
  output fan_strobe_t       strobe
);

  fan_state_t        state;
  logic [SLOT_W-1:0] slotQ;
  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  idxQ;
  logic              fire;
  logic              lastMember;
  logic              accept;

  assign accept     = (state == ST_IDLE) && xlValid;
  assign xlReady    = (state == ST_IDLE);
  assign rspValid   = (state == ST_SEND) ? (PORTS'(1) << rdPort) : '0;
  assign fire       = |(rspValid & rspReady);
  assign lastMember = (idxQ == countQ - CNT_W'(1));
  assign freeEn     = fire && lastMember;
  assign lockValid  = (state == ST_SEND);
  assign curSlot    = slotQ;
  assign curIdx     = idxQ;

  assign strobe.capture = accept && lookHit;
  assign strobe.lead    = (idxQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotQ   <= '0;
      countQ  <= '0;
      idxQ    <= '0;
      errMiss <= 1'b0;
    end else begin
      errMiss <= accept && !lookHit;
      case (state)
        ST_IDLE: begin
          if (accept && lookHit) begin
            state  <= ST_SEND;
            slotQ  <= lookSlot;
            countQ <= lookCount;
            idxQ   <= '0;
          end
        end
        ST_SEND: begin
          if (fire) begin
            if (lastMember) begin
              state <= ST_IDLE;
              idxQ  <= '0;
            end else begin
              idxQ <= idxQ + CNT_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xlate_fan_datapath.sv
module xlate_fan_datapath
  import xlate_fan_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DEPTH_W = 3,
  parameter int HIT_W   = 2,
  localparam int SHIFT_W = $clog2(ADDR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fan_strobe_t        strobe,
  input  logic [ADDR_W-1:0]  xlPaddr,
  input  logic [SHIFT_W-1:0] xlShift,
  input  logic               xlUncache,
  input  logic [HIT_W-1:0]   xlHitLevel,
  input  logic [ADDR_W-1:0]  rdVaddr,
  input  logic               rdPrefetch,
  input  logic [DEPTH_W-1:0] rdDepth,
  output logic [ADDR_W-1:0]  rspPaddr,
  output logic               rspUncache,
  output logic [HIT_W-1:0]   rspHitLevel,
  output logic [DEPTH_W-1:0] rspDepth,
  output logic               rspLead
);

  logic [ADDR_W-1:0] paddrQ;
  logic [ADDR_W-1:0] maskQ;
  logic              uncQ;
  logic [HIT_W-1:0]  hitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddrQ <= '0;
      maskQ  <= '0;
      uncQ   <= 1'b0;
      hitQ   <= '0;
    end else if (strobe.capture) begin
      paddrQ <= xlPaddr;
      maskQ  <= (ADDR_W'(1) << xlShift) - ADDR_W'(1);
      uncQ   <= xlUncache;
      hitQ   <= xlHitLevel;
    end
  end

  always_comb begin
    if (strobe.lead) rspPaddr = paddrQ;
    else             rspPaddr = (paddrQ & ~maskQ) | (rdVaddr & maskQ);
  end

  always_comb begin
    if (rdPrefetch || rdDepth == '0) rspDepth = rdDepth;
    else                             rspDepth = rdDepth - DEPTH_W'(1);
  end

  assign rspUncache  = uncQ;
  assign rspHitLevel = hitQ;
  assign rspLead     = strobe.lead;

endmodule

// File: rtl/xlate_fan_dist.sv
module xlate_fan_dist
  import xlate_fan_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BASE_SHIFT = 4,
  parameter int GROUPS     = 4,
  parameter int MEMBERS    = 4,
  parameter int PORTS      = 4,
  parameter int DEPTH_W    = 3,
  parameter int HIT_W      = 2,
  localparam int SLOT_W    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int CNT_W     = $clog2(MEMBERS + 1),
  localparam int PORT_W    = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int PAGE_W    = ADDR_W - BASE_SHIFT,
  localparam int SHIFT_W   = $clog2(ADDR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               insValid,
  input  logic [SLOT_W-1:0]  insSlot,
  input  logic [ADDR_W-1:0]  insVaddr,
  input  logic [PORT_W-1:0]  insPort,
  input  logic               insPrefetch,
  input  logic [DEPTH_W-1:0] insDepth,
  input  logic               xlValid,
  output logic               xlReady,
  input  logic [PAGE_W-1:0]  xlPage,
  input  logic [ADDR_W-1:0]  xlPaddr,
  input  logic [SHIFT_W-1:0] xlShift,
  input  logic               xlUncache,
  input  logic [HIT_W-1:0]   xlHitLevel,
  output logic [PORTS-1:0]   rspValid,
  input  logic [PORTS-1:0]   rspReady,
  output logic [ADDR_W-1:0]  rspPaddr,
  output logic               rspUncache,
  output logic [HIT_W-1:0]   rspHitLevel,
  output logic [DEPTH_W-1:0] rspDepth,
  output logic               rspLead,
  output logic               errMiss
);

  fan_strobe_t        strobe;
  logic               lookHit;
  logic [SLOT_W-1:0]  lookSlot;
  logic [CNT_W-1:0]   lookCount;
  logic [SLOT_W-1:0]  curSlot;
  logic [CNT_W-1:0]   curIdx;
  logic               lockValid;
  logic               freeEn;
  logic [ADDR_W-1:0]  rdVaddr;
  logic [PORT_W-1:0]  rdPort;
  logic               rdPrefetch;
  logic [DEPTH_W-1:0] rdDepth;

  xlate_fan_table #(
    .ADDR_W(ADDR_W), .BASE_SHIFT(BASE_SHIFT), .GROUPS(GROUPS),
    .MEMBERS(MEMBERS), .PORTS(PORTS), .DEPTH_W(DEPTH_W)
  ) uTable (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insSlot(insSlot), .insVaddr(insVaddr),
    .insPort(insPort), .insPrefetch(insPrefetch), .insDepth(insDepth),
    .lockValid(lockValid), .lockSlot(curSlot), .freeEn(freeEn),
    .lookPage(xlPage), .lookHit(lookHit), .lookSlot(lookSlot),
    .lookCount(lookCount),
    .rdSlot(curSlot), .rdIdx(curIdx), .rdVaddr(rdVaddr), .rdPort(rdPort),
    .rdPrefetch(rdPrefetch), .rdDepth(rdDepth)
  );

  xlate_fan_ctrl #(
    .GROUPS(GROUPS), .MEMBERS(MEMBERS), .PORTS(PORTS)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .xlValid(xlValid), .xlReady(xlReady),
    .lookHit(lookHit), .lookSlot(lookSlot), .lookCount(lookCount),
    .rdPort(rdPort), .rspReady(rspReady), .rspValid(rspValid),
    .curSlot(curSlot), .curIdx(curIdx), .lockValid(lockValid),
    .freeEn(freeEn), .errMiss(errMiss), .strobe(strobe)
  );

  xlate_fan_datapath #(
    .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .HIT_W(HIT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .xlPaddr(xlPaddr), .xlShift(xlShift), .xlUncache(xlUncache),
    .xlHitLevel(xlHitLevel),
    .rdVaddr(rdVaddr), .rdPrefetch(rdPrefetch), .rdDepth(rdDepth),
    .rspPaddr(rspPaddr), .rspUncache(rspUncache), .rspHitLevel(rspHitLevel),
    .rspDepth(rspDepth), .rspLead(rspLead)
  );

endmodule

// File: rtl/xlate_fan_chk.sv
module xlate_fan_chk #(
  parameter int ADDR_W = 16,
  parameter int PORTS  = 4,
  parameter int HIT_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              xlValid,
  input logic              xlReady,
  input logic [PORTS-1:0]  rspValid,
  input logic [PORTS-1:0]  rspReady,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic              rspUncache,
  input logic [HIT_W-1:0]  rspHitLevel,
  input logic              errMiss
);

  assert_onehot_rsp_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspValid));

  assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid != '0 && (rspValid & rspReady) == '0)
      |=> ($stable(rspValid) && $stable(rspPaddr) &&
           $stable(rspUncache) && $stable(rspHitLevel)));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid != '0) |-> !xlReady);

  assert_miss_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    errMiss |-> ($past(xlValid && xlReady) && rspValid == '0));

  assert_miss_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    errMiss |=> !errMiss);

endmodule

bind xlate_fan_dist xlate_fan_chk #(
  .ADDR_W(ADDR_W), .PORTS(PORTS), .HIT_W(HIT_W)
) uChk (
  .clk(clk), .rstN(rstN), .xlValid(xlValid), .xlReady(xlReady),
  .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr),
  .rspUncache(rspUncache), .rspHitLevel(rspHitLevel), .errMiss(errMiss)
);

// File: tb/tb_xlate_fan_dist.sv
module tb_xlate_fan_dist;

  localparam int AW = 16;
  localparam int BS = 4;
  localparam int NG = 4;
  localparam int NM = 4;
  localparam int NP = 4;
  localparam int DW = 3;
  localparam int HW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          insValid = 1'b0;
  logic [1:0]    insSlot = '0;
  logic [AW-1:0] insVaddr = '0;
  logic [1:0]    insPort = '0;
  logic          insPrefetch = 1'b0;
  logic [DW-1:0] insDepth = '0;
  logic          xlValid = 1'b0;
  logic          xlReady;
  logic [AW-BS-1:0] xlPage = '0;
  logic [AW-1:0] xlPaddr = '0;
  logic [3:0]    xlShift = '0;
  logic          xlUncache = 1'b0;
  logic [HW-1:0] xlHitLevel = '0;
  logic [NP-1:0] rspValid;
  logic [NP-1:0] rspReady = '0;
  logic [AW-1:0] rspPaddr;
  logic          rspUncache;
  logic [HW-1:0] rspHitLevel;
  logic [DW-1:0] rspDepth;
  logic          rspLead;
  logic          errMiss;

  int errors = 0;
  int checks = 0;

  // bench model of the table
  int            mCount [NG];
  logic [AW-1:0] mVaddr [NG][NM];
  int            mPort  [NG][NM];
  bit            mPf    [NG][NM];
  int            mDepth [NG][NM];

  xlate_fan_dist #(
    .ADDR_W(AW), .BASE_SHIFT(BS), .GROUPS(NG), .MEMBERS(NM),
    .PORTS(NP), .DEPTH_W(DW), .HIT_W(HW)
  ) dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelInstall(input int slot, input logic [AW-1:0] va,
                              input int port, input bit pf, input int dep,
                              input int lockSlot);
    if (slot == lockSlot) return;          // R11: locked slot drops installs
    if (mCount[slot] < NM) begin           // R10: capacity limit
      mVaddr[slot][mCount[slot]] = va;
      mPort[slot][mCount[slot]]  = port;
      mPf[slot][mCount[slot]]    = pf;
      mDepth[slot][mCount[slot]] = dep;
      mCount[slot]++;
    end
  endtask

  task automatic driveIns(input int slot, input logic [AW-1:0] va,
                          input int port, input bit pf, input int dep);
    insValid = 1'b1; insSlot = 2'(slot); insVaddr = va;
    insPort = 2'(port); insPrefetch = pf; insDepth = DW'(dep);
  endtask

  task automatic install(input int slot, input logic [AW-1:0] va,
                         input int port, input bit pf, input int dep);
    driveIns(slot, va, port, pf, dep);
    @(negedge clk);
    insValid = 1'b0;
    modelInstall(slot, va, port, pf, dep, -1);
  endtask

  // returns a translation for a slot's group and collects all responses
  task automatic runGroup(input int slot, input logic [AW-1:0] pa, input int sh,
                          input bit unc, input int hit, input int mode,
                          input bit inject, input int injSlot);
    int got = 0;
    int cyc = 0;
    int expN = mCount[slot];
    logic [AW-1:0] mask = (AW'(1) << sh) - AW'(1);
    logic [AW-1:0] expPa;
    int expDep;
    bit rdy;
    xlValid = 1'b1; xlPage = mVaddr[slot][0][AW-1:BS]; xlPaddr = pa;
    xlShift = 4'(sh); xlUncache = unc; xlHitLevel = HW'(hit);
    @(negedge clk);
    xlValid = 1'b0;
    while (got < expN && cyc < 60) begin
      if (inject && cyc == 0) begin
        driveIns(injSlot, 16'h7770, 1, 1'b0, 3);
        modelInstall(injSlot, 16'h7770, 1, 1'b0, 3, slot);
      end
      check(rspValid == NP'(1 << mPort[slot][got]), "R4", "port bit",
            int'(rspValid), 1 << mPort[slot][got]);
      check(!xlReady, "R8", "ready while busy", int'(xlReady), 0);
      rdy = (mode == 0) || (mode == 1 && cyc % 2 == 1) || (mode == 2 && cyc % 3 == 2);
      if (rdy) begin
        expPa = (got == 0) ? pa : ((pa & ~mask) | (mVaddr[slot][got] & mask));
        check(rspPaddr == expPa, got == 0 ? "R1" : "R2", "paddr",
              int'(rspPaddr), int'(expPa));
        check(rspLead == (got == 0), "R1", "lead", int'(rspLead), int'(got == 0));
        check(rspUncache == unc && rspHitLevel == HW'(hit), "R3", "unc/hit",
              int'({rspUncache, rspHitLevel}), int'({unc, HW'(hit)}));
        expDep = (mPf[slot][got] || mDepth[slot][got] == 0) ?
                 mDepth[slot][got] : mDepth[slot][got] - 1;
        check(int'(rspDepth) == expDep, "R7", "depth", int'(rspDepth), expDep);
        rspReady = rspValid;
        got++;
      end else begin
        rspReady = '0;
      end
      @(negedge clk);
      insValid = 1'b0;
      cyc++;
    end
    rspReady = '0;
    check(got == expN, "R5", "member count", got, expN);
    check(xlReady && rspValid == '0, "R8", "idle after last",
          int'({xlReady, rspValid}), int'({1'b1, 4'b0}));
    mCount[slot] = 0;
  endtask

  task automatic missCheck(input logic [AW-BS-1:0] page, input string req);
    xlValid = 1'b1; xlPage = page; xlPaddr = 16'h1234; xlShift = 4'd4;
    @(negedge clk);
    xlValid = 1'b0;
    check(errMiss == 1'b1, req, "miss flag", int'(errMiss), 1);
    check(rspValid == '0 && xlReady, "R9", "no response on miss",
          int'({xlReady, rspValid}), int'({1'b1, 4'b0}));
    @(negedge clk);
    check(errMiss == 1'b0, "R9", "miss pulse width", int'(errMiss), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    for (int g = 0; g < NG; g++) mCount[g] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(xlReady && rspValid == '0 && !errMiss, "R8", "reset state",
          int'({xlReady, rspValid, errMiss}), int'({1'b1, 4'b0, 1'b0}));

    // sweep: page sizes x ready patterns x group sizes (R1-related tags below)
    for (int si = 0; si < 3; si++) begin
      for (int mode = 0; mode < 3; mode++) begin
        int sh = 4 + 2 * si;
        int slot = (si + mode) % NG;
        int n = 1 + (si * 3 + mode) % NM;
        logic [AW-1:0] base = AW'(si * 3 + mode + 1) << 8;
        for (int i = 0; i < n; i++) begin
          logic [AW-1:0] off = AW'(i * 37 + mode * 5 + 3) & ((AW'(1) << sh) - AW'(1));
          if (i == 0) off = off & AW'(15);  // leader keys the base page (R10)
          install(slot, base | off, (i + mode + si) % NP, i == 2, (i + mode) % 8);
        end
        runGroup(slot, 16'hA5C3 ^ AW'(si * 1111 + mode * 77), sh,
                 (si + mode) % 2 == 1, (si + mode) % 4, mode, 1'b0, 0);
        // R8: entry released, same page now misses
        missCheck(base[AW-1:BS], "R8");
      end
    end

    // R9: page never installed
    missCheck(12'hFFF, "R9");

    // R10: capacity, fifth install dropped
    for (int i = 0; i < 5; i++) install(1, 16'h4200 | AW'(i * 3), i % NP, 1'b0, 5);
    check(mCount[1] == NM, "R10", "model capacity", mCount[1], NM);
    runGroup(1, 16'hC000, 8, 1'b1, 2, 0, 1'b0, 0);

    // two open groups, lookup picks by page
    install(0, 16'h5100, 2, 1'b0, 1);
    install(3, 16'h6100, 3, 1'b1, 4);
    install(3, 16'h6105, 0, 1'b0, 0);
    runGroup(3, 16'h9900, 4, 1'b0, 1, 1, 1'b0, 0);
    // R11: install into the slot being answered is dropped
    install(0, 16'h5102, 1, 1'b0, 2);
    runGroup(0, 16'h8800, 4, 1'b1, 3, 2, 1'b1, 0);
    // R11: install into another slot while answering is kept
    install(2, 16'h3300, 0, 1'b0, 6);
    runGroup(2, 16'h2200, 4, 1'b0, 0, 0, 1'b1, 1);
    check(mCount[1] == 1, "R11", "model kept install", mCount[1], 1);
    runGroup(1, 16'hE000, 4, 1'b0, 2, 0, 1'b0, 0);

    // R10: freed slot reusable with a new page
    install(2, 16'h0A10, 3, 1'b0, 7);
    runGroup(2, 16'hBEE0, 4, 1'b1, 1, 0, 1'b0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule